// File: doc/BRIEF.md
# Interrupt Queue Pending Detector

This block stores the head and tail offsets of four in-memory interrupt queues (processor mondo, device mondo, resumable error and non-resumable error) and tells the trap logic which of them hold unserviced entries. Software, or the producer hardware on its behalf, moves the offsets through a small register port: one request per cycle, with a valid strobe, a write flag, a register select and write data. Reads come back on a registered data bus one cycle later.

A queue counts as pending whenever its head offset differs from its tail offset. Three of the queues drive an interrupt-pending output. The non-resumable error queue keeps its two offsets, which can be read back, but it never raises an interrupt. The pending outputs are flops that take their new value at the same clock edge that stores the offset, so a consumer sees the change in the cycle after the write. Queue memory, entry address generation and trap delivery belong to other blocks.

Top module: `iq_pend_detect`

## Requirements
- R1: `irq_cpu_mondo` is 1 exactly when the processor mondo head (queue index 0) differs from its tail.
- R2: `irq_dev_mondo` is 1 exactly when the device mondo head (queue index 1) differs from its tail.
- R3: `irq_res_err` is 1 exactly when the resumable error head (queue index 2) differs from its tail.
- R4: The non-resumable error queue (index 3) stores a head and a tail that read back as written, and writing them never changes any interrupt output.
- R5: A write to a head or a tail is stored at the clock edge that accepts it, and the affected pending output shows the new comparison from the cycle after that edge. With no request, the outputs hold their value.
- R6: A read (`req_valid`=1, `req_write`=0) returns the selected register on `rd_data`, with `rd_valid`=1, in the cycle after the request, and changes no stored offset and no output. In any cycle that follows a non-read, `rd_valid` is 0.
- R7: Select encoding: bit 0 picks head (0) or tail (1), bits 2:1 pick the queue index, and all higher select bits must be zero. A write to any other select value is ignored; a read of one returns zero with `rd_valid`=1.
- R8: While reset (`rst_n`=0) is asserted, every offset is cleared, all interrupt outputs are 0, `rd_valid` is 0 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_sel | input | SEL_W | Register select (see R7) |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | DATA_W | Read data, one cycle after the read request |
| irq_cpu_mondo | output | 1 | Processor mondo queue not empty |
| irq_dev_mondo | output | 1 | Device mondo queue not empty |
| irq_res_err | output | 1 | Resumable error queue not empty |

## Verification
The bench builds the block with `DATA_W`=4 and the default 8-bit select. With four-bit offsets, every head and tail pairing of each queue (256 per queue) can be written and checked against an arithmetic comparison, so both equal and unequal cases and every bit position of the comparator are hit. The 8-bit select is small enough to read all 256 select values and write every unmapped one, covering the full decode of R7.

// File: rtl/iq_pkg.sv
package iq_pkg;

   localparam int unsigned IQ_COUNT = 4;
   localparam int unsigned IQ_IDX_W = 2;

   typedef enum logic [IQ_IDX_W-1:0] {
      IQ_CPU  = 2'd0,
      IQ_DEV  = 2'd1,
      IQ_RES  = 2'd2,
      IQ_NRES = 2'd3
   } iq_id_e;

   localparam logic [IQ_COUNT-1:0] IQ_REPORTS = 4'b0111;

endpackage

// File: rtl/iq_sel_decode.sv
module iq_sel_decode
   import iq_pkg::*;
#(
   parameter int unsigned SEL_W = 8
) (
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [SEL_W-1:0]    req_sel,
   output logic                sel_hit,
   output logic [IQ_IDX_W-1:0] sel_q,
   output logic                sel_tail,
   output logic [IQ_COUNT-1:0] wr_head,
   output logic [IQ_COUNT-1:0] wr_tail
);

   localparam int unsigned LOW_W = IQ_IDX_W + 1;

   generate
      if (SEL_W < LOW_W) begin : g_bad_sel
         $error("iq_sel_decode: SEL_W too small for the select encoding");
      end
   endgenerate

   logic [SEL_W-1:0] upper_bits;

   always_comb begin
      upper_bits = req_sel >> LOW_W;
      sel_hit    = (upper_bits == '0);
      sel_tail   = req_sel[0];
      sel_q      = req_sel[IQ_IDX_W:1];
   end

   generate
      for (genvar q = 0; q < IQ_COUNT; q++) begin : g_we
         logic q_match;
         assign q_match    = req_valid && req_write && sel_hit &&
                             (sel_q == IQ_IDX_W'(q));
         assign wr_head[q] = q_match && !sel_tail;
         assign wr_tail[q] = q_match &&  sel_tail;
      end
   endgenerate

endmodule

// File: rtl/iq_pair.sv
module iq_pair #(
   parameter int unsigned DATA_W  = 64,
   parameter bit          REPORTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_head,
   input  logic              wr_tail,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head_q,
   output logic [DATA_W-1:0] tail_q,
   output logic              pend_q
);

   logic [DATA_W-1:0] head_d;
   logic [DATA_W-1:0] tail_d;

   always_comb begin
      head_d = wr_head ? wdata : head_q;
      tail_d = wr_tail ? wdata : tail_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_d;
         tail_q <= tail_d;
      end
   end

   generate
      if (REPORTS) begin : g_pend
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else if (wr_head || wr_tail) begin
               pend_q <= (head_d != tail_d);
            end
         end
      end else begin : g_silent
         assign pend_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/iq_rd_port.sv
module iq_rd_port
   import iq_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_req,
   input  logic                       sel_hit,
   input  logic [IQ_IDX_W-1:0]        sel_q,
   input  logic                       sel_tail,
   input  logic [IQ_COUNT*DATA_W-1:0] head_flat,
   input  logic [IQ_COUNT*DATA_W-1:0] tail_flat,
   output logic                       rd_valid,
   output logic [DATA_W-1:0]          rd_data
);

   logic [DATA_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int q = 0; q < IQ_COUNT; q++) begin
         if (sel_hit && sel_q == IQ_IDX_W'(q)) begin
            pick = sel_tail ? tail_flat[q*DATA_W +: DATA_W]
                            : head_flat[q*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_data <= pick;
         end
      end
   end

endmodule

// File: rtl/iq_pend_detect.sv
module iq_pend_detect
   import iq_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SEL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_cpu_mondo,
   output logic              irq_dev_mondo,
   output logic              irq_res_err
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("iq_pend_detect: DATA_W must be at least 1");
      end
   endgenerate

   logic                       sel_hit;
   logic [IQ_IDX_W-1:0]        sel_q;
   logic                       sel_tail;
   logic [IQ_COUNT-1:0]        wr_head;
   logic [IQ_COUNT-1:0]        wr_tail;
   logic [IQ_COUNT*DATA_W-1:0] head_flat;
   logic [IQ_COUNT*DATA_W-1:0] tail_flat;
   logic [IQ_COUNT-1:0]        pend;

   iq_sel_decode #(.SEL_W(SEL_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_sel   (req_sel),
      .sel_hit   (sel_hit),
      .sel_q     (sel_q),
      .sel_tail  (sel_tail),
      .wr_head   (wr_head),
      .wr_tail   (wr_tail)
   );

   generate
      for (genvar q = 0; q < IQ_COUNT; q++) begin : g_q
         iq_pair #(
            .DATA_W  (DATA_W),
            .REPORTS (IQ_REPORTS[q])
         ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_head (wr_head[q]),
            .wr_tail (wr_tail[q]),
            .wdata   (req_wdata),
            .head_q  (head_flat[q*DATA_W +: DATA_W]),
            .tail_q  (tail_flat[q*DATA_W +: DATA_W]),
            .pend_q  (pend[q])
         );
      end
   endgenerate

   iq_rd_port #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (req_valid && !req_write),
      .sel_hit   (sel_hit),
      .sel_q     (sel_q),
      .sel_tail  (sel_tail),
      .head_flat (head_flat),
      .tail_flat (tail_flat),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   assign irq_cpu_mondo = pend[IQ_CPU];
   assign irq_dev_mondo = pend[IQ_DEV];
   assign irq_res_err   = pend[IQ_RES];

endmodule

// File: rtl/iq_pend_detect_chk.sv
module iq_pend_detect_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SEL_W  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [SEL_W-1:0]    req_sel,
   input logic                rd_valid,
   input logic [DATA_W-1:0]   rd_data,
   input logic                irq_cpu_mondo,
   input logic                irq_dev_mondo,
   input logic                irq_res_err,
   input logic [4*DATA_W-1:0] head_flat,
   input logic [4*DATA_W-1:0] tail_flat
);

   logic [2:0]       irqs;
   logic             is_read;
   logic             is_write;
   logic [SEL_W-1:0] sel_upper;

   assign irqs      = {irq_res_err, irq_dev_mondo, irq_cpu_mondo};
   assign is_read   = req_valid && !req_write;
   assign is_write  = req_valid && req_write;
   assign sel_upper = req_sel >> 3;

   assert_cpu_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cpu_mondo == (head_flat[DATA_W-1:0] != tail_flat[DATA_W-1:0]));

   assert_dev_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_dev_mondo == (head_flat[2*DATA_W-1:DATA_W] != tail_flat[2*DATA_W-1:DATA_W]));

   assert_res_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_res_err == (head_flat[3*DATA_W-1:2*DATA_W] != tail_flat[3*DATA_W-1:2*DATA_W]));

   assert_nres_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_write && sel_upper == '0 && req_sel[2:1] == 2'd3) |=> $stable(irqs));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(irqs));

   assert_read_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_read |=> ($stable(irqs) && $stable(head_flat) && $stable(tail_flat)));

   assert_read_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_read |=> rd_valid);

   assert_no_read_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_read |=> !rd_valid);

   assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_write && sel_upper != '0) |=> ($stable(head_flat) && $stable(tail_flat)));

   assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && sel_upper != '0) |=> (rd_data == '0));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R8: assert (irqs == 3'b000 && !rd_valid && rd_data == '0);
      end
   end

endmodule

bind iq_pend_detect iq_pend_detect_chk #(
   .DATA_W (DATA_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_write     (req_write),
   .req_sel       (req_sel),
   .rd_valid      (rd_valid),
   .rd_data       (rd_data),
   .irq_cpu_mondo (irq_cpu_mondo),
   .irq_dev_mondo (irq_dev_mondo),
   .irq_res_err   (irq_res_err),
   .head_flat     (head_flat),
   .tail_flat     (tail_flat)
);

// File: tb/iq_pend_detect_tb.sv
module iq_pend_detect_tb;

   localparam int unsigned DW = 4;
   localparam int unsigned SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [SW-1:0] req_sel = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          irq_cpu_mondo;
   logic          irq_dev_mondo;
   logic          irq_res_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [DW-1:0] m_head [4];
   logic [DW-1:0] m_tail [4];

   always #2 clk = ~clk;

   iq_pend_detect #(.DATA_W(DW), .SEL_W(SW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_sel       (req_sel),
      .req_wdata     (req_wdata),
      .rd_valid      (rd_valid),
      .rd_data       (rd_data),
      .irq_cpu_mondo (irq_cpu_mondo),
      .irq_dev_mondo (irq_dev_mondo),
      .irq_res_err   (irq_res_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int q = 0; q < 4; q++) begin
         m_head[q] = '0;
         m_tail[q] = '0;
      end
   endtask

   task automatic check_irqs(input string req);
      check({req, " cpu"}, 32'(irq_cpu_mondo), 32'(m_head[0] != m_tail[0]));
      check({req, " dev"}, 32'(irq_dev_mondo), 32'(m_head[1] != m_tail[1]));
      check({req, " res"}, 32'(irq_res_err),   32'(m_head[2] != m_tail[2]));
   endtask

   task automatic do_write(input logic [SW-1:0] sel, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_sel   = sel;
      req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      if ((sel >> 3) == 0) begin
         if (sel[0]) m_tail[sel[2:1]] = d;
         else        m_head[sel[2:1]] = d;
      end
   endtask

   task automatic do_read(input logic [SW-1:0] sel, input string req);
      logic [DW-1:0] exp;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b0;
      req_sel   = sel;
      @(negedge clk);
      req_valid = 1'b0;
      exp = '0;
      if ((sel >> 3) == 0) exp = sel[0] ? m_tail[sel[2:1]] : m_head[sel[2:1]];
      check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
      check({req, " rd_data"}, 32'(rd_data), 32'(exp));
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      // R8: reset state at the ports
      check("R8 irq_cpu", 32'(irq_cpu_mondo), 32'd0);
      check("R8 irq_dev", 32'(irq_dev_mondo), 32'd0);
      check("R8 irq_res", 32'(irq_res_err), 32'd0);
      check("R8 rd_valid", 32'(rd_valid), 32'd0);
      check("R8 rd_data", 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      model_clear();
   endtask

   initial begin
      model_clear();
      apply_reset();
      for (int s = 0; s < 8; s++) do_read(SW'(s), "R8 cleared offset");

      // R1 R2 R3 R5: every head/tail pair per reporting queue
      for (int q = 0; q < 3; q++) begin
         for (int h = 0; h < 16; h++) begin
            for (int t = 0; t < 16; t++) begin
               do_write(SW'(2*q), DW'(h));
               check_irqs("R5 after head write");
               do_write(SW'(2*q + 1), DW'(t));
               if (q == 0) check_irqs("R1 sweep");
               else if (q == 1) check_irqs("R2 sweep");
               else check_irqs("R3 sweep");
            end
         end
      end

      // R4: non-resumable queue stores but stays silent
      do_write(8'd0, 4'd3);
      do_write(8'd1, 4'd9);
      for (int h = 0; h < 16; h++) begin
         do_write(8'd6, DW'(h));
         do_write(8'd7, DW'(15 - h));
         check_irqs("R4 silent");
         do_read(8'd6, "R4 head");
         do_read(8'd7, "R4 tail");
      end

      // R5: outputs hold with no request
      repeat (5) @(negedge clk);
      check_irqs("R5 idle hold");

      // R6: reads of every select, no side effects, rd_valid drops after
      for (int s = 0; s < 256; s++) begin
         do_read(SW'(s), "R6/R7 read sweep");
      end
      check_irqs("R6 no side effect");
      @(negedge clk);
      check("R6 rd_valid low", 32'(rd_valid), 32'd0);

      // R7: writes to unmapped selects are ignored
      for (int s = 8; s < 256; s++) begin
         do_write(SW'(s), 4'hA);
      end
      check_irqs("R7 unmapped write");
      for (int s = 0; s < 8; s++) do_read(SW'(s), "R7 unmapped write state");

      // R8: reset mid-run clears everything
      do_write(8'd2, 4'd5);
      apply_reset();
      for (int s = 0; s < 8; s++) do_read(SW'(s), "R8 offset after reset");
      check_irqs("R8 after reset");

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule